// File: doc/BRIEF.md
# Synchronous Glitch-Free Clock Stop Gate

This block drives three families of clock outputs (processor-side differential pairs, PCI-side single-ended lines including free-runnable PCIF lines, and serial-reference differential pairs) and stops or restarts them on request without ever producing a partial pulse. Each family's waveform is produced from a phase generator clocked by one reference clock. The generator's half period is a parameter counted in reference cycles. A family is stopped by parking its outputs at a fixed level. Processor and serial-reference pairs park with the true leg high and the complement leg low. Single-ended lines park low.

Two active-low stop pins feed the block, one for the processor family and one for the PCI and serial-reference families. A software run bit acts as a second source of PCI-side stop requests. Each request is re-timed on two rising edges of the domain it controls. Mask bits choose which processor, PCIF and serial-reference outputs obey their stop request. The plain PCI lines always obey theirs, and unmasked outputs keep running. Per-output enable bits force both legs of an output low, whatever the stop state.

The gate changes only while the domain's phase sits at that output's park level. Because of this, the last pulse before a stop and the first pulse after a restart both have full width. All control pins are plain levels; the block has no data stream.

Top module: `clk_stop_gate`

## Requirements
- R1: With cpu_stop_n held low and cpu_stoppable[i]=1, cpu_t[i]=1 and cpu_c[i]=0 within six processor periods, and they stay parked while the pin stays low.
- R2: After cpu_stop_n returns high, a stopped processor output makes its first edge within three processor periods plus two reference cycles.
- R3: An output whose mask bit is 0 (cpu_stoppable, pcif_stoppable or src_stoppable) keeps toggling with exact half periods through any stop request. A stop in one domain never disturbs the other domain.
- R4: With pci_stop_n held low, every pci_o line and every PCIF line with pcif_stoppable=1 are parked low. Every serial-reference pair with src_stoppable=1 is parked with src_t=1 and src_c=0. All of these park within six periods of their domain and resume with a first edge within three periods plus two reference cycles after release.
- R5: sw_pci_run=0 requests a PCI-side stop exactly as pci_stop_n=0 does, and sw_pci_run=1 withdraws it. The two sources combine by OR.
- R6: No runt or stretched pulse: every pulse at the non-park level lasts exactly the domain half period. Every pulse at the park level lasts the half period plus a whole number of full periods.
- R7: An enable bit at 0 drives both legs of that output low, independent of the stop state. With the enable at 1, each complement leg is the inverse of its true leg.
- R8: While rst_n is low, every phase is low and every gate is open, so true legs and single-ended lines read 0 and enabled complement legs read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock for all phase generators |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Active-low processor stop request (asynchronous) |
| pci_stop_n | input | 1 | Active-low PCI-side stop request (asynchronous) |
| sw_pci_run | input | 1 | Software run bit, 0 requests a PCI-side stop |
| cpu_stoppable | input | NCPU | 1 = processor output obeys cpu_stop_n |
| pcif_stoppable | input | NPCIF | 1 = PCIF line obeys the PCI-side stop |
| src_stoppable | input | NSRC | 1 = serial-reference pair obeys the PCI-side stop |
| cpu_oe | input | NCPU | Processor output enables |
| pci_oe | input | NPCI | PCI line enables |
| pcif_oe | input | NPCIF | PCIF line enables |
| src_oe | input | NSRC | Serial-reference output enables |
| cpu_t | output | NCPU | Processor true legs |
| cpu_c | output | NCPU | Processor complement legs |
| pci_o | output | NPCI | PCI single-ended lines |
| pcif_o | output | NPCIF | PCIF single-ended lines |
| src_t | output | NSRC | Serial-reference true legs |
| src_c | output | NSRC | Serial-reference complement legs |

## Verification
The bench measures the width of every high and low pulse on all true legs and single-ended lines. It also toggles stop pins and the software bit at random times against random masks. A gate that switched mid-pulse would show up as a short or odd-length pulse, and a mask applied to the wrong output would show up as a parked pulse on a free-running line. Directed cases hold each stop long enough to catch a design that never parks or parks at the wrong level, for example differential pairs parked low or single-ended lines parked high. They also time the first edge after release, which exposes an extra synchroniser stage or a restart that waits a whole extra period. Disabled outputs are watched while stops toggle, to catch an enable that is overridden by the stop logic.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  typedef enum logic {PARK_LOW = 1'b0, PARK_HIGH = 1'b1} park_e;
endpackage

// File: rtl/cs_phase_gen.sv
module cs_phase_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase,
  output logic rise
);
  localparam int CW = $clog2(HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == LAST);
  assign rise = wrap && !phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6: a rise marker is always followed by the phase going high
  p_rise_lead_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> phase);
endmodule

// File: rtl/cs_stop_sync.sv
module cs_stop_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic req,
  output logic stop
);
  logic s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b0;
      stop <= 1'b0;
    end else if (rise) begin
      s1   <= req;
      stop <= s1;
    end
  end

  // R1: the re-timed request moves only on a domain rising edge
  p_sync_on_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stop) |-> $past(rise));
endmodule

// File: rtl/cs_gate_leg.sv
module cs_gate_leg
  import clkstop_pkg::*;
#(
  parameter park_e PARK = PARK_LOW
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phase,
  input  logic stop,
  output logic gated
);
  localparam logic PL = (PARK == PARK_HIGH);

  logic run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run_q <= 1'b1;
    else if (phase == PL) run_q <= ~stop;
  end

  assign gated = run_q ? phase : PL;

  // R6: the gate leaves the park level only together with the phase
  p_leave_park_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gated) == PL && gated != PL) |-> ($past(phase) == PL && phase != PL));

  // R6: the gate reaches the park level only on a phase edge
  p_enter_park_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gated) != PL && gated == PL) |-> ($past(phase) != PL && phase == PL));
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
  import clkstop_pkg::*;
#(
  parameter int NCPU     = 2,
  parameter int NPCI     = 3,
  parameter int NPCIF    = 1,
  parameter int NSRC     = 2,
  parameter int CPU_HALF = 2,
  parameter int PCI_HALF = 5,
  parameter int SRC_HALF = 3
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             cpu_stop_n,
  input  logic             pci_stop_n,
  input  logic             sw_pci_run,
  input  logic [NCPU-1:0]  cpu_stoppable,
  input  logic [NPCIF-1:0] pcif_stoppable,
  input  logic [NSRC-1:0]  src_stoppable,
  input  logic [NCPU-1:0]  cpu_oe,
  input  logic [NPCI-1:0]  pci_oe,
  input  logic [NPCIF-1:0] pcif_oe,
  input  logic [NSRC-1:0]  src_oe,
  output logic [NCPU-1:0]  cpu_t,
  output logic [NCPU-1:0]  cpu_c,
  output logic [NPCI-1:0]  pci_o,
  output logic [NPCIF-1:0] pcif_o,
  output logic [NSRC-1:0]  src_t,
  output logic [NSRC-1:0]  src_c
);
  logic cpu_ph, cpu_rise, pci_ph, pci_rise, src_ph, src_rise;
  logic cpu_stop, pci_stop, src_stop;
  logic cpu_req, pci_req;

  assign cpu_req = ~cpu_stop_n;
  assign pci_req = ~pci_stop_n | ~sw_pci_run;

  cs_phase_gen #(.HALF(CPU_HALF)) u_cpu_ph (.clk(clk_ref), .rst_n(rst_n), .phase(cpu_ph), .rise(cpu_rise));
  cs_phase_gen #(.HALF(PCI_HALF)) u_pci_ph (.clk(clk_ref), .rst_n(rst_n), .phase(pci_ph), .rise(pci_rise));
  cs_phase_gen #(.HALF(SRC_HALF)) u_src_ph (.clk(clk_ref), .rst_n(rst_n), .phase(src_ph), .rise(src_rise));

  cs_stop_sync u_cpu_sync (.clk(clk_ref), .rst_n(rst_n), .rise(cpu_rise), .req(cpu_req), .stop(cpu_stop));
  cs_stop_sync u_pci_sync (.clk(clk_ref), .rst_n(rst_n), .rise(pci_rise), .req(pci_req), .stop(pci_stop));
  cs_stop_sync u_src_sync (.clk(clk_ref), .rst_n(rst_n), .rise(src_rise), .req(pci_req), .stop(src_stop));

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    logic g;
    cs_gate_leg #(.PARK(PARK_HIGH)) u_leg (
      .clk(clk_ref), .rst_n(rst_n), .phase(cpu_ph),
      .stop(cpu_stop & cpu_stoppable[i]), .gated(g));
    assign cpu_t[i] = cpu_oe[i] & g;
    assign cpu_c[i] = cpu_oe[i] & ~g;
  end

  for (genvar i = 0; i < NPCI; i++) begin : g_pci
    logic g;
    cs_gate_leg #(.PARK(PARK_LOW)) u_leg (
      .clk(clk_ref), .rst_n(rst_n), .phase(pci_ph),
      .stop(pci_stop), .gated(g));
    assign pci_o[i] = pci_oe[i] & g;
  end

  for (genvar i = 0; i < NPCIF; i++) begin : g_pcif
    logic g;
    cs_gate_leg #(.PARK(PARK_LOW)) u_leg (
      .clk(clk_ref), .rst_n(rst_n), .phase(pci_ph),
      .stop(pci_stop & pcif_stoppable[i]), .gated(g));
    assign pcif_o[i] = pcif_oe[i] & g;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic g;
    cs_gate_leg #(.PARK(PARK_HIGH)) u_leg (
      .clk(clk_ref), .rst_n(rst_n), .phase(src_ph),
      .stop(src_stop & src_stoppable[i]), .gated(g));
    assign src_t[i] = src_oe[i] & g;
    assign src_c[i] = src_oe[i] & ~g;
  end
endmodule

// File: tb/test_clk_stop_gate.sv
module test_clk_stop_gate;
  localparam int CH = 2, PH = 5, SH = 3;
  localparam int CP = 2*CH, PP = 2*PH, SP = 2*SH;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, sw_pci_run = 1'b1;
  logic [1:0] cpu_stoppable = '0, src_stoppable = '0;
  logic [0:0] pcif_stoppable = '0, pcif_oe = '1, pcif_o;
  logic [1:0] cpu_oe = '1, src_oe = '1, cpu_t, cpu_c, src_t, src_c;
  logic [2:0] pci_oe = '1, pci_o;
  logic [7:0] mon_sig;

  int checks = 0, fails = 0, comp_err = 0;
  bit mon_en = 0, seg_cpu = 0, seg_pci = 0, done = 0;
  int lvl[8], len[8];
  bit have[8];

  always #10 clk = ~clk;

  clk_stop_gate i_clk_stop_gate (
    .clk_ref(clk), .rst_n(rst_n), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
    .sw_pci_run(sw_pci_run), .cpu_stoppable(cpu_stoppable), .pcif_stoppable(pcif_stoppable),
    .src_stoppable(src_stoppable), .cpu_oe(cpu_oe), .pci_oe(pci_oe), .pcif_oe(pcif_oe),
    .src_oe(src_oe), .cpu_t(cpu_t), .cpu_c(cpu_c), .pci_o(pci_o), .pcif_o(pcif_o),
    .src_t(src_t), .src_c(src_c));

  assign mon_sig = {src_t, pcif_o, pci_o, cpu_t};

  function automatic int half_of(int i);
    if (i < 2) return CH;
    if (i < 6) return PH;
    return SH;
  endfunction

  function automatic int park_of(int i);
    return (i < 2 || i > 5) ? 1 : 0;
  endfunction

  function automatic bit may_stop(int i);
    if (i < 2)  return cpu_stoppable[i] && seg_cpu;
    if (i < 5)  return seg_pci;
    if (i == 5) return pcif_stoppable[0] && seg_pci;
    return src_stoppable[i-6] && seg_pci;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // pulse-width monitor (R6, R3) and complement watch (R7)
  always @(negedge clk) begin
    if (!mon_en) begin
      for (int i = 0; i < 8; i++) have[i] = 0;
      seg_cpu = 0; seg_pci = 0;
    end else begin
      if (!cpu_stop_n) seg_cpu = 1;
      if (!pci_stop_n || !sw_pci_run) seg_pci = 1;
      if (cpu_c != ~cpu_t || src_c != ~src_t) comp_err++;
      for (int i = 0; i < 8; i++) begin
        if (!have[i]) begin
          have[i] = 1; lvl[i] = mon_sig[i]; len[i] = -1;
        end else if (mon_sig[i] != lvl[i]) begin
          if (len[i] > 0) begin
            int h;
            h = half_of(i);
            if (lvl[i] != park_of(i))
              chk(len[i] == h, "R6", $sformatf("active pulse out%0d", i), len[i], h);
            else if (may_stop(i))
              chk(len[i] % (2*h) == h, "R6", $sformatf("park pulse out%0d", i), len[i], h);
            else
              chk(len[i] == h, "R3", $sformatf("free-running out%0d", i), len[i], h);
          end
          lvl[i] = mon_sig[i]; len[i] = 1;
        end else if (len[i] > 0) len[i]++;
      end
    end
  end

  task automatic seg_restart();
    mon_en = 0;
    repeat (2) @(negedge clk);
    mon_en = 1;
  endtask

  task automatic wait_edge(int idx, int limit, output int n);
    logic v0;
    v0 = mon_sig[idx];
    n = 0;
    while (mon_sig[idx] == v0 && n <= limit) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, moves;
    bit ok;
    void'($urandom(32'h5eed_c10c));
    // R8 reset state
    repeat (5) @(negedge clk);
    chk(cpu_t == 2'b00 && cpu_c == 2'b11, "R8", "cpu legs in reset", {cpu_t, cpu_c}, 4'b0011);
    chk(pci_o == 3'b000 && pcif_o == 1'b0, "R8", "pci lines in reset", {pci_o, pcif_o}, 0);
    chk(src_t == 2'b00 && src_c == 2'b11, "R8", "src legs in reset", {src_t, src_c}, 4'b0011);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R2/R3: processor stop, output 0 masked, output 1 free
    cpu_stoppable = 2'b01;
    seg_restart();
    repeat (10) @(negedge clk);
    cpu_stop_n = 1'b0;
    repeat (6*CP) @(negedge clk);
    ok = 1; moves = 0;
    for (int k = 0; k < 2*CP; k++) begin
      if (!(cpu_t[0] == 1'b1 && cpu_c[0] == 1'b0)) ok = 0;
      if (pci_o[0] != pcif_o[0]) ok = 0;
      @(negedge clk);
    end
    chk(ok, "R1", "cpu0 parked true high", cpu_t[0], 1);
    cpu_stop_n = 1'b1;
    wait_edge(0, 3*CP+2, n);
    chk(n <= 3*CP+2, "R2", "cpu0 first edge latency", n, 3*CP+2);
    repeat (20) @(negedge clk);

    // R4/R3: pin stop, pcif masked, src0 masked, src1 free
    pcif_stoppable = 1'b1; src_stoppable = 2'b01;
    seg_restart();
    repeat (10) @(negedge clk);
    pci_stop_n = 1'b0;
    repeat (6*PP) @(negedge clk);
    ok = 1; moves = 0;
    for (int k = 0; k < 2*PP; k++) begin
      logic s1;
      s1 = src_t[1];
      if (pci_o != 3'b000 || pcif_o != 1'b0) ok = 0;
      if (!(src_t[0] == 1'b1 && src_c[0] == 1'b0)) ok = 0;
      @(negedge clk);
      if (src_t[1] != s1) moves++;
    end
    chk(ok, "R4", "pci/pcif low, src0 parked high", {pci_o, pcif_o, src_t[0]}, 1);
    chk(moves > 0, "R3", "src1 keeps toggling", moves, 1);
    pci_stop_n = 1'b1;
    wait_edge(2, 3*PP+2, n);
    chk(n <= 3*PP+2, "R4", "pci0 first edge latency", n, 3*PP+2);
    repeat (40) @(negedge clk);

    // R5: software run bit as a stop source
    pcif_stoppable = 1'b0; src_stoppable = 2'b10;
    seg_restart();
    repeat (10) @(negedge clk);
    sw_pci_run = 1'b0;
    repeat (6*PP) @(negedge clk);
    ok = 1; moves = 0;
    for (int k = 0; k < 2*PP; k++) begin
      logic f;
      f = pcif_o[0];
      if (pci_o != 3'b000 || !(src_t[1] == 1'b1 && src_c[1] == 1'b0)) ok = 0;
      @(negedge clk);
      if (pcif_o[0] != f) moves++;
    end
    chk(ok, "R5", "software stop parks pci and src1", {pci_o, src_t[1]}, 1);
    chk(moves > 0, "R3", "unmasked pcif keeps toggling", moves, 1);
    sw_pci_run = 1'b1;
    wait_edge(2, 3*PP+2, n);
    chk(n <= 3*PP+2, "R5", "software release latency", n, 3*PP+2);
    repeat (40) @(negedge clk);

    // R7: disabled outputs stay low on both legs while stops toggle
    mon_en = 0;
    @(negedge clk);
    cpu_oe = 2'b10; pci_oe = 3'b101; src_oe = 2'b10;
    ok = 1;
    for (int k = 0; k < 120; k++) begin
      if (k % 17 == 0) begin cpu_stop_n = ~cpu_stop_n; pci_stop_n = ~pci_stop_n; end
      @(negedge clk);
      if (cpu_t[0] || cpu_c[0] || pci_o[1] || src_t[0] || src_c[0]) ok = 0;
    end
    chk(ok, "R7", "disabled legs low", {cpu_t[0], cpu_c[0], pci_o[1], src_t[0], src_c[0]}, 0);
    cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
    cpu_oe = '1; pci_oe = '1; src_oe = '1;
    repeat (60) @(negedge clk);

    // random segments: R6 and R3 through the pulse monitor
    for (int s = 0; s < 30; s++) begin
      cpu_stoppable  = 2'($urandom);
      pcif_stoppable = 1'($urandom);
      src_stoppable  = 2'($urandom);
      seg_restart();
      for (int t = 0; t < 8; t++) begin
        case ($urandom % 4)
          0: cpu_stop_n = ~cpu_stop_n;
          1: pci_stop_n = ~pci_stop_n;
          2: sw_pci_run = ~sw_pci_run;
          default: ;
        endcase
        repeat (1 + $urandom % 60) @(negedge clk);
      end
      cpu_stop_n = 1'b1; pci_stop_n = 1'b1; sw_pci_run = 1'b1;
      repeat (60) @(negedge clk);
    end
    mon_en = 0;
    chk(comp_err == 0, "R7", "complement legs inverse of true", comp_err, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule